// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Entry

This block manages one entry of a flat, memory-based coherence directory. It does not keep one presence bit for every node. It records up to a few sharer node IDs in pointer slots. Each slot is as wide as a node ID. When a new sharer arrives and every slot is already in use, the entry applies an overflow policy. The policy is chosen on an input at the moment the overflow happens:

- **Broadcast:** the entry marks itself as broadcast.
- **Replace:** the entry evicts one recorded sharer and asks for that sharer to be invalidated.
- **Coarse:** the entry reinterprets its pointer storage as a vector with one bit per group of nodes.

Commands arrive one at a time on a valid/ready port. Each command carries a node ID and is one of three kinds: add a sharer, clear the entry, or a write by a node. A write turns the current sharer set into a list of nodes to invalidate. The list leaves the block one ID per cycle on a second valid/ready port and ends with a single-cycle done pulse. The writer then becomes the only recorded sharer. Network messaging and line data sit outside the block.

Top module: `dir_lptr_entry`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `inv_valid` and `inv_done` are 0. A write to a freshly reset entry produces a done pulse with no invalidations.
- R2: `cmd_op` encoding is 0 = no operation, 1 = add sharer, 2 = clear entry, 3 = write. A no-operation command changes nothing. Adding a node that is already recorded in a pointer is also a no-op. Both of these produce no invalidation.
- R3: A write while the entry is in pointer form invalidates every recorded sharer except the writer. The IDs are emitted in ascending order, one per accepted handshake. `inv_done` is high for exactly one cycle, in the cycle after the last handshake, and `inv_valid` is low during that cycle.
- R4: After a write stream completes, the entry holds the writer as its only sharer, in pointer form.
- R5: `ovf_mode` 0 (and also 3) selects broadcast. In this mode, adding a new sharer when all `NPTR` slots are full sets the entry to broadcast. A later write then invalidates every node from 0 to `NODES`-1 except the writer.
- R6: `ovf_mode` 1 selects replace. A new sharer that arrives with all slots full overwrites the slot picked by a round-robin index. Slots are filled in the order 0..`NPTR`-1, and the index starts at slot 0 after reset, clear or write. The displaced node is emitted as the only ID of a stream that ends with a done pulse.
- R7: `ovf_mode` 2 selects coarse. On overflow, the entry becomes a vector with one bit per group g, and group g holds the nodes with ID / `GRP_K` = g (`GRP_K` = 3 with the defaults). The bits set are those for the groups of all recorded sharers and the new one. Later adds set their group's bit. A write invalidates every node in each set group except the writer.
- R8: A clear command empties the entry, whatever its form, and emits no invalidation.
- R9: While `inv_valid` is high and `inv_ready` is low, `inv_node` holds steady. `cmd_ready` is low from the acceptance of a stream-producing command until the cycle after its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command kind (see R2) |
| cmd_node | input | ID_W | Node ID carried by the command |
| ovf_mode | input | 2 | Overflow policy applied when the slots are full |
| cmd_ready | output | 1 | Entry can take a command |
| inv_valid | output | 1 | An invalidation target is presented |
| inv_ready | input | 1 | Consumer takes the presented target |
| inv_node | output | ID_W | Node ID to invalidate |
| inv_done | output | 1 | One-cycle pulse ending an invalidation stream |

## Verification
The bound checker watches the output handshake on every cycle:
- the node ID stays stable under backpressure;
- no command is accepted while a list is pending;
- the done pulse lasts one cycle and never overlaps a valid ID;
- a write stream never names the writer;
- a replacement stream carries exactly one ID.

Which nodes appear in a stream depends on the history of adds, duplicates, clears and overflow mode, so only the bench's scenarios show it. These scenarios cover the round-robin victim sequence, the coarse group arithmetic, the broadcast sweep and the single sharer left after a write.

// File: rtl/dir_lptr_pkg.sv
package dir_lptr_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ADD = 2'd1,
    OP_CLR = 2'd2,
    OP_WR  = 2'd3
  } dir_op_e;

  typedef enum logic [1:0] {
    OVF_BCAST  = 2'd0,
    OVF_REPL   = 2'd1,
    OVF_COARSE = 2'd2,
    OVF_ALT    = 2'd3
  } ovf_mode_e;

  typedef enum logic [1:0] {
    FMT_PTR    = 2'd0,
    FMT_BCAST  = 2'd1,
    FMT_COARSE = 2'd2
  } entry_fmt_e;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/dir_ptr_store.sv
module dir_ptr_store
  import dir_lptr_pkg::*;
#(
  parameter int NODES   = 64,
  parameter int NPTR    = 4,
  parameter int ID_W    = 6,
  parameter int STORE_W = 24,
  parameter int GRP_K   = 3,
  parameter int GROUPS  = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic             clr_en,
  input  logic             commit_en,
  input  logic [ID_W-1:0]  node,
  input  logic [ID_W-1:0]  commit_node,
  input  logic [1:0]       ovf_mode,
  output logic [NODES-1:0] member,
  output logic             repl_fire,
  output logic [ID_W-1:0]  repl_node,
  output entry_fmt_e       fmt_o
);

  localparam int RR_W = (NPTR > 1) ? $clog2(NPTR) : 1;

  logic [STORE_W-1:0] store_q;
  logic [NPTR-1:0]    vld_q;
  entry_fmt_e         fmt_q;
  logic [RR_W-1:0]    rr_q;

  logic               hit;
  logic               free_any;
  int                 free_idx;
  logic [STORE_W-1:0] cvec;

  function automatic int grp_of(input logic [ID_W-1:0] id);
    return int'(id) / GRP_K;
  endfunction

  function automatic logic [ID_W-1:0] slot(input logic [STORE_W-1:0] s, input int j);
    return s[j*ID_W +: ID_W];
  endfunction

  always_comb begin
    hit      = 1'b0;
    free_any = 1'b0;
    free_idx = 0;
    for (int j = 0; j < NPTR; j++) begin
      if (vld_q[j] && slot(store_q, j) == node) hit = 1'b1;
    end
    for (int j = NPTR - 1; j >= 0; j--) begin
      if (!vld_q[j]) begin
        free_any = 1'b1;
        free_idx = j;
      end
    end
  end

  always_comb begin
    cvec = '0;
    for (int j = 0; j < NPTR; j++) begin
      if (vld_q[j]) cvec[grp_of(slot(store_q, j))] = 1'b1;
    end
    cvec[grp_of(node)] = 1'b1;
  end

  always_comb begin
    for (int n = 0; n < NODES; n++) begin
      member[n] = 1'b0;
      unique case (fmt_q)
        FMT_BCAST:  member[n] = 1'b1;
        FMT_COARSE: member[n] = store_q[n / GRP_K];
        default: begin
          for (int j = 0; j < NPTR; j++) begin
            if (vld_q[j] && int'(slot(store_q, j)) == n) member[n] = 1'b1;
          end
        end
      endcase
    end
  end

  assign repl_fire = add_en && (fmt_q == FMT_PTR) && !hit && !free_any &&
                     (ovf_mode == OVF_REPL);
  assign repl_node = slot(store_q, int'(rr_q));
  assign fmt_o     = fmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      vld_q   <= '0;
      fmt_q   <= FMT_PTR;
      rr_q    <= '0;
    end else if (clr_en) begin
      store_q <= '0;
      vld_q   <= '0;
      fmt_q   <= FMT_PTR;
      rr_q    <= '0;
    end else if (commit_en) begin
      store_q             <= '0;
      store_q[0 +: ID_W]  <= commit_node;
      vld_q               <= NPTR'(1);
      fmt_q               <= FMT_PTR;
      rr_q                <= '0;
    end else if (add_en) begin
      unique case (fmt_q)
        FMT_COARSE: store_q[grp_of(node)] <= 1'b1;
        FMT_BCAST:  ;
        default: begin
          if (hit) begin
            // already recorded: nothing to do
          end else if (free_any) begin
            store_q[free_idx*ID_W +: ID_W] <= node;
            vld_q[free_idx]                <= 1'b1;
          end else begin
            unique case (ovf_mode)
              OVF_REPL: begin
                store_q[int'(rr_q)*ID_W +: ID_W] <= node;
                rr_q <= (rr_q == RR_W'(NPTR - 1)) ? '0 : rr_q + 1'b1;
              end
              OVF_COARSE: begin
                store_q <= cvec;
                vld_q   <= '0;
                fmt_q   <= FMT_COARSE;
              end
              default: fmt_q <= FMT_BCAST;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dir_inv_scan.sv
module dir_inv_scan #(
  parameter int NODES = 64,
  parameter int ID_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NODES-1:0] load_mask,
  input  logic             inv_ready,
  output logic             inv_valid,
  output logic [ID_W-1:0]  inv_node,
  output logic             done,
  output logic             busy
);

  logic [NODES-1:0] mask_q;
  logic             busy_q;
  logic [ID_W-1:0]  low_idx;

  always_comb begin
    low_idx = '0;
    for (int n = NODES - 1; n >= 0; n--) begin
      if (mask_q[n]) low_idx = ID_W'(n);
    end
  end

  assign inv_valid = busy_q && (|mask_q);
  assign done      = busy_q && !(|mask_q);
  assign inv_node  = low_idx;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      mask_q <= load_mask;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else if (inv_ready) mask_q[low_idx] <= 1'b0;
    end
  end

endmodule

// File: rtl/dir_lptr_entry.sv
module dir_lptr_entry
  import dir_lptr_pkg::*;
#(
  parameter int NODES = 64,
  parameter int NPTR  = 4,
  parameter int ID_W  = $clog2(NODES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [ID_W-1:0] cmd_node,
  input  logic [1:0]      ovf_mode,
  output logic            cmd_ready,
  output logic            inv_valid,
  input  logic            inv_ready,
  output logic [ID_W-1:0] inv_node,
  output logic            inv_done
);

  localparam int STORE_W = NPTR * ID_W;
  localparam int GRP_K   = int'(ceil_div(NODES, STORE_W));
  localparam int GROUPS  = int'(ceil_div(NODES, GRP_K));

  logic             cmd_fire, add_en, clr_en, wr_fire;
  logic             scan_busy, scan_done, scan_load;
  logic [NODES-1:0] member, wr_mask, repl_mask, load_mask;
  logic             repl_fire;
  logic [ID_W-1:0]  repl_node;
  entry_fmt_e       fmt;
  logic             scan_is_write;
  logic [ID_W-1:0]  scan_writer;

  assign cmd_ready = !scan_busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign add_en    = cmd_fire && (cmd_op == OP_ADD);
  assign clr_en    = cmd_fire && (cmd_op == OP_CLR);
  assign wr_fire   = cmd_fire && (cmd_op == OP_WR);

  always_comb begin
    for (int n = 0; n < NODES; n++) begin
      wr_mask[n]   = member[n] && (int'(cmd_node) != n);
      repl_mask[n] = (int'(repl_node) == n);
    end
  end

  assign scan_load = wr_fire || repl_fire;
  assign load_mask = wr_fire ? wr_mask : repl_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_is_write <= 1'b0;
      scan_writer   <= '0;
    end else if (wr_fire) begin
      scan_is_write <= 1'b1;
      scan_writer   <= cmd_node;
    end else if (scan_done) begin
      scan_is_write <= 1'b0;
    end
  end

  dir_ptr_store #(
    .NODES(NODES), .NPTR(NPTR), .ID_W(ID_W),
    .STORE_W(STORE_W), .GRP_K(GRP_K), .GROUPS(GROUPS)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .add_en     (add_en),
    .clr_en     (clr_en),
    .commit_en  (scan_done && scan_is_write),
    .node       (cmd_node),
    .commit_node(scan_writer),
    .ovf_mode   (ovf_mode),
    .member     (member),
    .repl_fire  (repl_fire),
    .repl_node  (repl_node),
    .fmt_o      (fmt)
  );

  dir_inv_scan #(.NODES(NODES), .ID_W(ID_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (scan_load),
    .load_mask(load_mask),
    .inv_ready(inv_ready),
    .inv_valid(inv_valid),
    .inv_node (inv_node),
    .done     (scan_done),
    .busy     (scan_busy)
  );

  assign inv_done = scan_done;

endmodule

// File: rtl/dir_lptr_chk.sv
module dir_lptr_chk #(
  parameter int ID_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_ready,
  input logic            inv_valid,
  input logic            inv_ready,
  input logic [ID_W-1:0] inv_node,
  input logic            inv_done,
  input logic            scan_is_write,
  input logic [ID_W-1:0] scan_writer
);

  p_hold_node_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_node));

  p_no_cmd_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !cmd_ready);

  p_done_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> !inv_valid && !cmd_ready);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |=> !inv_done);

  p_skip_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && scan_is_write |-> inv_node != scan_writer);

  p_single_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ready && !scan_is_write |=> !inv_valid);

endmodule

bind dir_lptr_entry dir_lptr_chk #(.ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_ready    (cmd_ready),
  .inv_valid    (inv_valid),
  .inv_ready    (inv_ready),
  .inv_node     (inv_node),
  .inv_done     (inv_done),
  .scan_is_write(scan_is_write),
  .scan_writer  (scan_writer)
);

// File: tb/dir_lptr_entry_bench.sv
module dir_lptr_entry_bench;

  localparam int NODES = 64;
  localparam int ID_W  = 6;
  localparam int K     = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic [1:0]      cmd_op = 2'd0;
  logic [ID_W-1:0] cmd_node = '0;
  logic [1:0]      ovf_mode = 2'd0;
  logic            cmd_ready, inv_valid, inv_done;
  logic            inv_ready = 1'b1;
  logic [ID_W-1:0] inv_node;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int got[0:NODES];
  int got_n;

  always #2 clk = ~clk;

  dir_lptr_entry u_dir_lptr_entry (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_node(cmd_node), .ovf_mode(ovf_mode), .cmd_ready(cmd_ready),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
    .inv_done(inv_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input int node);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_node  = ID_W'(node);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
  endtask

  task automatic collect();
    got_n = 0;
    for (int c = 0; c < 400; c++) begin
      if (inv_done) return;
      if (inv_valid && inv_ready && got_n <= NODES) begin
        got[got_n] = int'(inv_node);
        got_n++;
      end
      @(negedge clk);
    end
    got_n = -1;
  endtask

  task automatic expect_stream(input logic [NODES-1:0] exp, input string req);
    int k;
    collect();
    k = 0;
    for (int n = 0; n < NODES; n++) begin
      if (exp[n]) begin
        if (k < got_n) chk(got[k] == n, req, "stream id", got[k], n);
        k++;
      end
    end
    chk(got_n == k, req, "stream length", got_n, k);
  endtask

  task automatic expect_quiet(input string req);
    chk(!inv_valid && !inv_done, req, "no invalidation", int'(inv_valid), 0);
  endtask

  function automatic logic [NODES-1:0] one(input int n);
    logic [NODES-1:0] m = '0;
    m[n] = 1'b1;
    return m;
  endfunction

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R1", "cmd_ready at reset", int'(cmd_ready), 1);
    chk(inv_valid == 1'b0, "R1", "inv_valid at reset", int'(inv_valid), 0);
    chk(inv_done == 1'b0, "R1", "inv_done at reset", int'(inv_done), 0);
    send(2'd3, 7);
    expect_stream('0, "R1");
  endtask

  task automatic t_pointers();
    send(2'd2, 0);
    send(2'd1, 10); expect_quiet("R2");
    send(2'd1, 3);
    send(2'd1, 10); expect_quiet("R2");
    send(2'd0, 50); expect_quiet("R2");
    send(2'd1, 40);
    send(2'd3, 3);
    expect_stream(one(10) | one(40), "R3");
    send(2'd3, 5);
    expect_stream(one(3), "R4");
    send(2'd3, 5);
    expect_stream('0, "R4");
  endtask

  task automatic t_clear();
    send(2'd1, 1);
    send(2'd1, 2);
    send(2'd2, 0); expect_quiet("R8");
    send(2'd3, 9);
    expect_stream('0, "R8");
  endtask

  task automatic t_bcast(input logic [1:0] mode);
    logic [NODES-1:0] e;
    send(2'd2, 0);
    ovf_mode = mode;
    for (int i = 1; i <= 5; i++) send(2'd1, i);
    expect_quiet("R5");
    send(2'd3, 2);
    e = '1; e[2] = 1'b0;
    expect_stream(e, "R5");
  endtask

  task automatic t_replace();
    send(2'd2, 0);
    ovf_mode = 2'd1;
    for (int i = 11; i <= 14; i++) send(2'd1, i);
    for (int i = 15; i <= 19; i++) begin
      send(2'd1, i);
      expect_stream(one(i - 4), "R6");
    end
    send(2'd1, 17); expect_quiet("R6");
    send(2'd3, 0);
    expect_stream(one(16) | one(17) | one(18) | one(19), "R6");
  endtask

  task automatic t_coarse();
    int ids[7] = '{0, 10, 20, 30, 63, 45, 44};
    logic [NODES-1:0] e;
    send(2'd2, 0);
    ovf_mode = 2'd2;
    foreach (ids[i]) send(2'd1, ids[i]);
    expect_quiet("R7");
    send(2'd3, 31);
    e = '0;
    for (int n = 0; n < NODES; n++) begin
      foreach (ids[i]) if (ids[i] / K == n / K) e[n] = 1'b1;
    end
    e[31] = 1'b0;
    expect_stream(e, "R7");
    send(2'd3, 60);
    expect_stream(one(31), "R7");
  endtask

  task automatic t_stall();
    int first;
    send(2'd2, 0);
    send(2'd1, 5); send(2'd1, 6); send(2'd1, 7);
    inv_ready = 1'b0;
    send(2'd3, 8);
    chk(inv_valid == 1'b1, "R9", "valid under stall", int'(inv_valid), 1);
    first = int'(inv_node);
    chk(first == 5, "R9", "first id", first, 5);
    repeat (3) @(negedge clk);
    chk(int'(inv_node) == first, "R9", "id held", int'(inv_node), first);
    chk(cmd_ready == 1'b0, "R9", "cmd_ready low", int'(cmd_ready), 0);
    inv_ready = 1'b1;
    expect_stream(one(5) | one(6) | one(7), "R9");
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "cmd_ready after done", int'(cmd_ready), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointers();
    t_clear();
    t_bcast(2'd0);
    t_bcast(2'd3);
    t_replace();
    t_coarse();
    t_stall();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule